// File: doc/BRIEF.md
# Stream-to-Memory Write DMA

This engine takes 32-bit words from a stream source and writes them to consecutive word addresses through a simple single-word write port carrying address, data, valid and ready. Software sets it up over an AXI4-Lite register port. It writes a run bit and an interrupt-enable bit into the control register, then the first destination address, then a byte length. The length write launches one transfer.

The transfer ends in one of two ways: the programmed number of bytes has been written, or a word arrives carrying TLAST. After the final word is accepted by memory, a sticky completion flag is set. When the interrupt is enabled, the flag drives the interrupt output. An interrupt handler clears the flag by writing one to it, then programs a new address and length. Back-to-back transfers can therefore fill memory contiguously.

Register offsets, taken from address bits [3:2]:

- 0x0 is control. Bit 0 is run and bit 12 is interrupt enable.
- 0x4 is status. Bit 0 is halted, bit 1 is idle, and bit 12 is the completion flag.
- 0x8 is the destination address.
- 0xC is the byte length.

Top module: `strm2mem_dma`

## Requirements
- R1: After reset, control reads 0x0, status reads 0x3 (halted and idle), and done_irq, st_tready and wr_valid are low.
- R2: Control bit 0 (run) and bit 12 (interrupt enable) are writable at offset 0x0 and read back. Every other control bit reads 0.
- R3: A write to the length register at 0xC launches a transfer of length/4 words only when run is 1, no transfer is active and the length is at least 4. In every other case the write starts nothing.
- R4: Accepted stream words are written in arrival order to the destination address, then +4, +8 and so on, with their data unchanged. The destination register forces bits [1:0] to 0.
- R5: st_tready is low whenever no transfer is armed or run is 0, so the source stalls and no word is lost.
- R6: A transfer ends after length/4 words, or earlier at the first accepted word with TLAST set, whichever comes first. After that no further word is accepted.
- R7: Status bit 12 is set once the final word of a transfer has been accepted by memory. Bit 1 reads 1 when no transfer is active and no word is pending. Bit 0 reads as the inverse of run.
- R8: Writing status with bit 12 set clears the completion flag. Writing status with bit 12 clear leaves it unchanged.
- R9: done_irq is high exactly while the completion flag and control bit 12 are both set.
- R10: While wr_valid is high and wr_ready is low, wr_valid, wr_addr and wr_data hold their values.
- R11: After a transfer completes, a new address and length start another transfer. Successive transfers to adjacent regions fill memory without gaps.
- R12: Write responses and read data stay valid until they are accepted. Both carry response code 0 (OKAY).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_awaddr | input | 4 | Register write address |
| cfg_awvalid | input | 1 | Write address valid |
| cfg_awready | output | 1 | Write address ready |
| cfg_wdata | input | 32 | Register write data |
| cfg_wvalid | input | 1 | Write data valid |
| cfg_wready | output | 1 | Write data ready |
| cfg_bresp | output | 2 | Write response code |
| cfg_bvalid | output | 1 | Write response valid |
| cfg_bready | input | 1 | Write response ready |
| cfg_araddr | input | 4 | Register read address |
| cfg_arvalid | input | 1 | Read address valid |
| cfg_arready | output | 1 | Read address ready |
| cfg_rdata | output | 32 | Register read data |
| cfg_rresp | output | 2 | Read response code |
| cfg_rvalid | output | 1 | Read data valid |
| cfg_rready | input | 1 | Read data ready |
| st_tdata | input | 32 | Stream word |
| st_tvalid | input | 1 | Stream word valid |
| st_tready | output | 1 | Stream ready |
| st_tlast | input | 1 | Final word of a packet |
| wr_addr | output | 32 | Memory write byte address |
| wr_data | output | 32 | Memory write data |
| wr_valid | output | 1 | Memory write request |
| wr_ready | input | 1 | Memory accepts request |
| done_irq | output | 1 | Completion interrupt |

## Verification
The assertions assume the register master presents a write address and its data together and keeps both valid until they are accepted. The bench drives them as a pair and holds them until ready, which satisfies that assumption. The stream source and the memory sink follow valid/ready rules, and the assertions about held outputs rely on that. The bench changes stream inputs and memory readiness only at the falling edge, and it sweeps memory readiness through always-ready, every-other-cycle and every-third-cycle patterns. Destination addresses and lengths are kept word-aligned and small enough to fit inside the bench memory model.

// File: rtl/sdma_pkg.sv
package sdma_pkg;
    localparam int REG_AW   = 4;
    localparam int WORD_W   = 32;
    localparam int RUN_BIT  = 0;
    localparam int IEN_BIT  = 12;
    localparam int HALT_BIT = 0;
    localparam int IDLE_BIT = 1;
    localparam int DONE_BIT = 12;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_STAT = 2'd1,
        SEL_DEST = 2'd2,
        SEL_LEN  = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/sdma_regs.sv
module sdma_regs
    import sdma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16,
    localparam int CNT_W = LEN_W - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] awaddr,
    input  logic              awvalid,
    output logic              awready,
    input  logic [WORD_W-1:0] wdata,
    input  logic              wvalid,
    output logic              wready,
    output logic              bvalid,
    input  logic              bready,
    input  logic [REG_AW-1:0] araddr,
    input  logic              arvalid,
    output logic              arready,
    output logic [WORD_W-1:0] rdata,
    output logic              rvalid,
    input  logic              rready,
    input  logic              busy_i,
    input  logic              done_i,
    output logic              run_o,
    output logic              ien_o,
    output logic              flag_o,
    output logic [ADDR_W-1:0] dest_o,
    output logic              start_o,
    output logic [CNT_W-1:0]  words_o
);
    typedef struct packed {
        logic              run;
        logic              ien;
        logic              done;
        logic [ADDR_W-1:0] dest;
        logic [LEN_W-1:0]  len;
        logic              bvalid;
        logic              rvalid;
        logic [WORD_W-1:0] rdata;
    } regs_t;

    regs_t q, d;
    logic  wr_fire, rd_fire, start_d;
    logic  unused_bits;

    assign wr_fire     = awvalid && wvalid && !q.bvalid;
    assign rd_fire     = arvalid && !q.rvalid;
    assign unused_bits = ^{awaddr[1:0], araddr[1:0], wdata};

    always_comb begin
        d       = q;
        start_d = 1'b0;
        if (q.bvalid && bready) d.bvalid = 1'b0;
        if (q.rvalid && rready) d.rvalid = 1'b0;
        if (wr_fire) begin
            d.bvalid = 1'b1;
            case (reg_sel_e'(awaddr[3:2]))
                SEL_CTRL: begin
                    d.run = wdata[RUN_BIT];
                    d.ien = wdata[IEN_BIT];
                end
                SEL_STAT: if (wdata[DONE_BIT]) d.done = 1'b0;
                SEL_DEST: d.dest = {wdata[ADDR_W-1:2], 2'b00};
                SEL_LEN: begin
                    d.len   = wdata[LEN_W-1:0];
                    start_d = q.run && !busy_i && (wdata[LEN_W-1:2] != '0);
                end
                default: ;
            endcase
        end
        if (done_i) d.done = 1'b1;
        if (rd_fire) begin
            d.rvalid = 1'b1;
            case (reg_sel_e'(araddr[3:2]))
                SEL_CTRL: d.rdata = (WORD_W'(q.run) << RUN_BIT) | (WORD_W'(q.ien) << IEN_BIT);
                SEL_STAT: d.rdata = (WORD_W'(q.done) << DONE_BIT)
                                  | (WORD_W'(!busy_i) << IDLE_BIT)
                                  | (WORD_W'(!q.run) << HALT_BIT);
                SEL_DEST: d.rdata = WORD_W'(q.dest);
                default:  d.rdata = WORD_W'(q.len);
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign awready = wr_fire;
    assign wready  = wr_fire;
    assign bvalid  = q.bvalid;
    assign arready = !q.rvalid;
    assign rvalid  = q.rvalid;
    assign rdata   = q.rdata;
    assign run_o   = q.run;
    assign ien_o   = q.ien;
    assign flag_o  = q.done;
    assign dest_o  = q.dest;
    assign start_o = start_d;
    assign words_o = wdata[LEN_W-1:2];
endmodule

// File: rtl/sdma_engine.sv
module sdma_engine
    import sdma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [CNT_W-1:0]  words_i,
    input  logic [WORD_W-1:0] tdata,
    input  logic              tvalid,
    input  logic              tlast,
    output logic              tready,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_data,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic              busy_o,
    output logic              done_o
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_W / 8);

    typedef struct packed {
        logic              active;
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  rem;
        logic              mvalid;
        logic [ADDR_W-1:0] maddr;
        logic [WORD_W-1:0] mdata;
        logic              mlast;
    } eng_t;

    eng_t q, d;
    logic accept, mem_fire, final_beat;

    assign tready     = q.active && run_i && (!q.mvalid || mem_ready);
    assign accept     = tready && tvalid;
    assign mem_fire   = q.mvalid && mem_ready;
    assign final_beat = (q.rem == CNT_W'(1)) || tlast;

    always_comb begin
        d = q;
        if (mem_fire) d.mvalid = 1'b0;
        if (accept) begin
            d.mvalid = 1'b1;
            d.maddr  = q.addr;
            d.mdata  = tdata;
            d.mlast  = final_beat;
            d.addr   = q.addr + STEP;
            d.rem    = q.rem - CNT_W'(1);
            if (final_beat) d.active = 1'b0;
        end
        if (start_i) begin
            d.active = 1'b1;
            d.addr   = base_i;
            d.rem    = words_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mem_addr  = q.maddr;
    assign mem_data  = q.mdata;
    assign mem_valid = q.mvalid;
    assign busy_o    = q.active || q.mvalid;
    assign done_o    = mem_fire && q.mlast;
endmodule

// File: rtl/strm2mem_dma.sv
module strm2mem_dma
    import sdma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] cfg_awaddr,
    input  logic              cfg_awvalid,
    output logic              cfg_awready,
    input  logic [WORD_W-1:0] cfg_wdata,
    input  logic              cfg_wvalid,
    output logic              cfg_wready,
    output logic [1:0]        cfg_bresp,
    output logic              cfg_bvalid,
    input  logic              cfg_bready,
    input  logic [REG_AW-1:0] cfg_araddr,
    input  logic              cfg_arvalid,
    output logic              cfg_arready,
    output logic [WORD_W-1:0] cfg_rdata,
    output logic [1:0]        cfg_rresp,
    output logic              cfg_rvalid,
    input  logic              cfg_rready,
    input  logic [WORD_W-1:0] st_tdata,
    input  logic              st_tvalid,
    output logic              st_tready,
    input  logic              st_tlast,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [WORD_W-1:0] wr_data,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic              done_irq
);
    localparam int CNT_W = LEN_W - 2;

    logic              ctrl_run, ctrl_ien, done_flag, eng_busy, eng_done, start;
    logic [ADDR_W-1:0] dest;
    logic [CNT_W-1:0]  words;

    sdma_regs #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) regs_i (
        .clk(clk), .rst_n(rst_n),
        .awaddr(cfg_awaddr), .awvalid(cfg_awvalid), .awready(cfg_awready),
        .wdata(cfg_wdata), .wvalid(cfg_wvalid), .wready(cfg_wready),
        .bvalid(cfg_bvalid), .bready(cfg_bready),
        .araddr(cfg_araddr), .arvalid(cfg_arvalid), .arready(cfg_arready),
        .rdata(cfg_rdata), .rvalid(cfg_rvalid), .rready(cfg_rready),
        .busy_i(eng_busy), .done_i(eng_done),
        .run_o(ctrl_run), .ien_o(ctrl_ien), .flag_o(done_flag),
        .dest_o(dest), .start_o(start), .words_o(words)
    );

    sdma_engine #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) eng_i (
        .clk(clk), .rst_n(rst_n),
        .run_i(ctrl_run), .start_i(start), .base_i(dest), .words_i(words),
        .tdata(st_tdata), .tvalid(st_tvalid), .tlast(st_tlast), .tready(st_tready),
        .mem_addr(wr_addr), .mem_data(wr_data), .mem_valid(wr_valid), .mem_ready(wr_ready),
        .busy_o(eng_busy), .done_o(eng_done)
    );

    assign cfg_bresp = 2'b00;
    assign cfg_rresp = 2'b00;
    assign done_irq  = done_flag && ctrl_ien;
endmodule

// File: rtl/sdma_chk.sv
module sdma_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              st_tvalid,
    input logic              st_tready,
    input logic              wr_valid,
    input logic              wr_ready,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [31:0]       wr_data,
    input logic              cfg_bvalid,
    input logic              cfg_bready,
    input logic              cfg_rvalid,
    input logic              cfg_rready,
    input logic [31:0]       cfg_rdata,
    input logic              run,
    input logic              busy,
    input logic              done_flag
);
    // R10
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));
    // R5
    halt_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !st_tready);
    // R4
    beat_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_tvalid && st_tready |=> wr_valid);
    // R7
    done_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_flag) |-> $past(busy));
    // R6
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_flag) |-> !st_tready);
    // R12
    bresp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_bvalid && !cfg_bready |=> cfg_bvalid);
    // R12
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rvalid && !cfg_rready |=> cfg_rvalid && $stable(cfg_rdata));
endmodule

bind strm2mem_dma sdma_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk(clk), .rst_n(rst_n),
    .st_tvalid(st_tvalid), .st_tready(st_tready),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .cfg_bvalid(cfg_bvalid), .cfg_bready(cfg_bready),
    .cfg_rvalid(cfg_rvalid), .cfg_rready(cfg_rready), .cfg_rdata(cfg_rdata),
    .run(ctrl_run), .busy(eng_busy), .done_flag(done_flag)
);

// File: tb/strm2mem_dma_tb_top.sv
module strm2mem_dma_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  awaddr = '0, araddr = '0;
    logic        awvalid = 0, wvalid = 0, bready = 0, arvalid = 0, rready = 0;
    logic [31:0] wdata = '0;
    logic        awready, wready, bvalid, arready, rvalid;
    logic [1:0]  bresp, rresp;
    logic [31:0] rdata;
    logic [31:0] st_tdata = '0;
    logic        st_tvalid = 0, st_tlast = 0, st_tready;
    logic [31:0] wr_addr, wr_data;
    logic        wr_valid, wr_ready = 1'b1;
    logic        done_irq;

    int          checks = 0, errors = 0, rdy_mode = 0, cyc = 0;
    logic [31:0] mem [1024];

    always #4 clk = ~clk;

    strm2mem_dma dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_awaddr(awaddr), .cfg_awvalid(awvalid), .cfg_awready(awready),
        .cfg_wdata(wdata), .cfg_wvalid(wvalid), .cfg_wready(wready),
        .cfg_bresp(bresp), .cfg_bvalid(bvalid), .cfg_bready(bready),
        .cfg_araddr(araddr), .cfg_arvalid(arvalid), .cfg_arready(arready),
        .cfg_rdata(rdata), .cfg_rresp(rresp), .cfg_rvalid(rvalid), .cfg_rready(rready),
        .st_tdata(st_tdata), .st_tvalid(st_tvalid), .st_tready(st_tready), .st_tlast(st_tlast),
        .wr_addr(wr_addr), .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .done_irq(done_irq)
    );

    always @(negedge clk) begin
        cyc = cyc + 1;
        case (rdy_mode)
            0:       wr_ready = 1'b1;
            1:       wr_ready = cyc[0];
            default: wr_ready = (cyc % 3 == 0);
        endcase
    end

    always @(posedge clk)
        if (rst_n && wr_valid && wr_ready) mem[wr_addr[11:2]] = wr_data;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic axi_write(input logic [3:0] a, input logic [31:0] d, input int bdelay);
        @(negedge clk); awaddr = a; awvalid = 1; wdata = d; wvalid = 1; bready = 0;
        #3; while (!awready) begin @(negedge clk); #3; end
        @(negedge clk); awvalid = 0; wvalid = 0;
        for (int k = 0; k < bdelay; k++) begin
            #3; check("R12 bvalid held", 32'(bvalid), 32'd1);
            @(negedge clk);
        end
        bready = 1;
        #3; while (!bvalid) begin @(negedge clk); #3; end
        if (bdelay > 0) check("R12 bresp", 32'(bresp), 32'd0);
        @(negedge clk); bready = 0;
    endtask

    task automatic axi_read(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk); araddr = a; arvalid = 1; rready = 1;
        #3; while (!arready) begin @(negedge clk); #3; end
        @(negedge clk); arvalid = 0;
        #3; while (!rvalid) begin @(negedge clk); #3; end
        d = rdata;
        check("R12 rresp", 32'(rresp), 32'd0);
        @(negedge clk); rready = 0;
    endtask

    task automatic expect_reg(input string req, input logic [3:0] a, input logic [31:0] exp);
        logic [31:0] v;
        axi_read(a, v);
        check(req, v, exp);
    endtask

    task automatic push(input int n, input logic [31:0] base, input int last_at);
        for (int i = 0; i < n; ) begin
            @(negedge clk); st_tvalid = 1; st_tdata = base + 32'(i); st_tlast = (i == last_at);
            #3; if (st_tready) i++;
        end
        @(negedge clk); st_tvalid = 0; st_tlast = 0;
    endtask

    task automatic expect_stall(input string req, input int cycles);
        @(negedge clk); st_tvalid = 1; st_tdata = 32'hBAD0BAD0;
        for (int k = 0; k < cycles; k++) begin
            #3; check(req, 32'(st_tready), 32'd0);
            @(negedge clk);
        end
        st_tvalid = 0;
    endtask

    task automatic fill_mem();
        for (int i = 0; i < 1024; i++) mem[i] = 32'hDEADBEEF;
    endtask

    task automatic settle();
        repeat (20) @(negedge clk);
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        fill_mem();
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        #3;
        check("R1 irq", 32'(done_irq), 0);
        check("R1 tready", 32'(st_tready), 0);
        check("R1 wr_valid", 32'(wr_valid), 0);
        expect_reg("R1 ctrl", 4'h0, 32'h0);
        expect_reg("R1 status", 4'h4, 32'h3);

        // R2 control readback, other bits masked
        axi_write(4'h0, 32'hFFFF_FFFF, 2);
        expect_reg("R2 ctrl all ones", 4'h0, 32'h1001);
        axi_write(4'h0, 32'h0000_1000, 0);
        expect_reg("R2 ctrl ien only", 4'h0, 32'h1000);

        // R3 length ignored while halted
        axi_write(4'h8, 32'h40, 0);
        axi_write(4'hC, 32'd16, 0);
        expect_reg("R3 halted stays idle", 4'h4, 32'h3);
        axi_write(4'h0, 32'h1001, 0);
        expect_stall("R3 halted launch ignored", 3);
        // R3 length below one word ignored
        axi_write(4'hC, 32'd3, 0);
        expect_reg("R3 short length idle", 4'h4, 32'h2);
        expect_stall("R3 short length ignored", 3);

        // R4 destination alignment
        axi_write(4'h8, 32'h0000_0087, 0);
        expect_reg("R4 dest aligned", 4'h8, 32'h84);

        // R4 R6 R7 R9 R8 sweep: ready patterns x word counts
        for (int m = 0; m < 3; m++) begin
            for (int c = 0; c < 5; c++) begin
                int n;
                n = (c == 4) ? 8 : c + 1;
                rdy_mode = m;
                fill_mem();
                axi_write(4'h8, 32'h80, 0);
                axi_write(4'hC, 32'(4 * n), 0);
                push(n, 32'h1000 * 32'(m + 1) + 32'h100 * 32'(n), -1);
                settle();
                for (int i = 0; i < n; i++)
                    check("R4 word", mem[32 + i], 32'h1000 * 32'(m + 1) + 32'h100 * 32'(n) + 32'(i));
                check("R6 no write past length", mem[32 + n], 32'hDEADBEEF);
                expect_stall("R6 no accept after count", 2);
                expect_reg("R7 done status", 4'h4, 32'h1002);
                check("R9 irq set", 32'(done_irq), 1);
                axi_write(4'h4, 32'h0, 0);
                expect_reg("R8 write zero keeps flag", 4'h4, 32'h1002);
                axi_write(4'h4, 32'h1000, 0);
                expect_reg("R8 cleared", 4'h4, 32'h2);
                #3; check("R9 irq cleared", 32'(done_irq), 0);
            end
        end
        rdy_mode = 0;

        // R6 early TLAST
        fill_mem();
        axi_write(4'h8, 32'h200, 0);
        axi_write(4'hC, 32'd32, 0);
        push(3, 32'hA0, 2);
        settle();
        check("R6 tlast word2", mem[130], 32'hA2);
        check("R6 tlast stops", mem[131], 32'hDEADBEEF);
        expect_stall("R6 no accept after tlast", 2);
        expect_reg("R7 tlast done", 4'h4, 32'h1002);

        // R9 flag with interrupt disabled
        axi_write(4'h0, 32'h1, 0);
        #3; check("R9 irq masked", 32'(done_irq), 0);
        axi_write(4'h0, 32'h1001, 0);
        #3; check("R9 irq unmasked", 32'(done_irq), 1);
        axi_write(4'h4, 32'h1000, 0);

        // R11 back-to-back contiguous
        fill_mem();
        axi_write(4'h8, 32'h300, 0);
        axi_write(4'hC, 32'd16, 0);
        push(4, 32'h500, -1);
        settle();
        axi_write(4'h4, 32'h1000, 0);
        axi_write(4'h8, 32'h310, 0);
        axi_write(4'hC, 32'd16, 0);
        push(4, 32'h504, -1);
        settle();
        for (int i = 0; i < 8; i++) check("R11 contiguous", mem[192 + i], 32'h500 + 32'(i));
        axi_write(4'h4, 32'h1000, 0);

        // R3 length write while busy ignored
        axi_write(4'h8, 32'h380, 0);
        axi_write(4'hC, 32'd8, 0);
        push(1, 32'h700, -1);
        axi_write(4'hC, 32'd64, 0);
        push(1, 32'h701, -1);
        settle();
        expect_stall("R3 busy launch ignored", 3);
        expect_reg("R7 busy case done", 4'h4, 32'h1002);
        axi_write(4'h4, 32'h1000, 0);

        // R5 R7 run cleared mid-transfer
        axi_write(4'h8, 32'h3C0, 0);
        axi_write(4'hC, 32'd8, 0);
        axi_write(4'h0, 32'h1000, 0);
        expect_stall("R5 halted stall", 3);
        expect_reg("R7 halted busy", 4'h4, 32'h1);
        axi_write(4'h0, 32'h1001, 0);
        push(2, 32'h900, -1);
        settle();
        check("R5 resumed data", mem[241], 32'h901);
        expect_reg("R7 resumed done", 4'h4, 32'h1002);

        finish_run();
    end
endmodule